// File: doc/BRIEF.md
# Pulse-Width Serial Bit Decoder

This block recovers bits from a slow single-wire diagnostic line on which every bit occupies a fixed-length cell. Each cell opens with the line falling low. How long the line then stays low carries the bit: a brief dip is a zero and a long dip is a one. The block takes the raw line through a synchronizer and a glitch filter and finds the falling edge that starts each cell. At a fixed delay after that edge it samples the filtered level. There it issues a one-cycle strobe with the decoded bit.

The block also watches the timing of each cell. It flags a cell whose low pulse does not end in time before the next start edge, and a start edge that arrives before the current cell was sampled. When the line stays quiet for longer than a cell and a half, the block raises a level flag that shows no bit stream is present. All timing is given in system clock ticks, and the defaults are worked out from the clock frequency. Level shifting, byte assembly and frame handling are left to the logic around the block.

Top module: `pwbit_decoder`

## Requirements
- R1: While reset is asserted and right after it, bitValid and timingErr are 0 and idle is 1.
- R2: A cell whose low pulse is well shorter than SAMPLE_TICKS gives exactly one bitValid pulse with bitValue 0 (line high at the sample point encodes 0).
- R3: A cell whose low pulse lasts past the sample point gives exactly one bitValid pulse with bitValue 1 (line low at the sample point encodes 1).
- R4: bitValid lasts one cycle. It comes SAMPLE_TICKS ticks after the filtered falling edge, plus a fixed pipeline latency of at most FILTER_LEN+6 cycles, and this delay is the same for every cell.
- R5: A line excursion shorter than FILTER_LEN clock cycles is ignored. It starts no cell, changes no decoded value and does not clear idle.
- R6: If the filtered line is still low CELL_TICKS-GUARD_TICKS ticks after the start edge, timingErr pulses for one cycle. The bit already sampled stays valid, and the block waits for a fresh falling edge.
- R7: A falling edge that arrives before the current cell has been sampled raises timingErr and starts a new cell at that edge. That new cell is then decoded normally.
- R8: With no falling edge for IDLE_TICKS ticks, idle goes to 1 and any cell still in progress is dropped. The next falling edge clears idle.
- R9: bitValid is never high in the same cycle as timingErr or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw asynchronous diagnostic line, high when at rest |
| bitValid | output | 1 | One-cycle strobe at each cell's sample point |
| bitValue | output | 1 | Decoded bit, valid while bitValid is high |
| timingErr | output | 1 | One-cycle strobe for a malformed cell |
| idle | output | 1 | High while no start edge has been seen for IDLE_TICKS |

## Verification
The bench drives one-pulses whose low phase ends just before the release limit and just after it. A design that compared against the raw line, or ran its release check at the wrong tick, would then flag a legal cell or miss a stuck one. Single-cycle blips placed inside low pulses and on a quiet line expose a missing or too-short filter: that design would start phantom cells or flip a bit. A second falling edge before the sample point checks that the cell restarts on the new edge with an error and not a lost bit. A long quiet gap checks that idle appears and is cleared by the next edge.

// File: rtl/pwbit_pkg.sv
package pwbit_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic takeSample;
    logic raiseErr;
    logic setIdle;
    logic clrIdle;
  } ctrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic fallEdge;
    logic atSample;
    logic atRelease;
    logic atIdle;
    logic lineLow;
  } stat_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_EARLY = 2'd1,
    ST_LATE  = 2'd2
  } state_t;

endpackage

// File: rtl/pwbit_datapath.sv
module pwbit_datapath
  import pwbit_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FILTER_LEN    = 4,
  parameter int SAMPLE_TICKS  = 95000,
  parameter int RELEASE_TICKS = 287500,
  parameter int IDLE_TICKS    = 468750
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  lineIn,
  input  ctrl_t ctrl,
  output stat_t stat,
  output logic  bitValid,
  output logic  bitValue,
  output logic  timingErr,
  output logic  idle
);

  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam int FW = (FILTER_LEN > 1) ? $clog2(FILTER_LEN + 1) : 1;

  // Synchronizer chain, resting high
  logic [SYNC_STAGES-1:0] syncReg;
  logic syncd;

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], lineIn};
  end
  assign syncd = syncReg[SYNC_STAGES-1];

  // Glitch filter: accept a new level only after FILTER_LEN disagreeing cycles
  logic filtLine;
  logic prevFilt;

  generate
    if (FILTER_LEN > 1) begin : g_filter
      logic [FW-1:0] agreeCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          agreeCnt <= '0;
          filtLine <= 1'b1;
        end else if (syncd == filtLine) begin
          agreeCnt <= '0;
        end else if (agreeCnt == FW'(FILTER_LEN - 1)) begin
          agreeCnt <= '0;
          filtLine <= syncd;
        end else begin
          agreeCnt <= agreeCnt + 1'b1;
        end
      end
    end else begin : g_nofilter
      always_ff @(posedge clk) begin
        if (!rstN) filtLine <= 1'b1;
        else       filtLine <= syncd;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevFilt <= 1'b1;
    else       prevFilt <= filtLine;
  end

  // Tick counter since the last accepted start edge, saturating
  logic [CW-1:0] cellCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                         cellCnt <= '0;
    else if (ctrl.clrCnt)              cellCnt <= '0;
    else if (cellCnt != CW'(IDLE_TICKS)) cellCnt <= cellCnt + 1'b1;
  end

  always_comb begin
    stat.fallEdge  = prevFilt & ~filtLine;
    stat.atSample  = (cellCnt == CW'(SAMPLE_TICKS));
    stat.atRelease = (cellCnt == CW'(RELEASE_TICKS));
    stat.atIdle    = (cellCnt == CW'(IDLE_TICKS - 1));
    stat.lineLow   = ~filtLine;
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitValid  <= 1'b0;
      bitValue  <= 1'b0;
      timingErr <= 1'b0;
      idle      <= 1'b1;
    end else begin
      bitValid  <= ctrl.takeSample;
      timingErr <= ctrl.raiseErr;
      if (ctrl.takeSample) bitValue <= ~filtLine;
      if (ctrl.clrIdle)      idle <= 1'b0;
      else if (ctrl.setIdle) idle <= 1'b1;
    end
  end

endmodule

// File: rtl/pwbit_control.sv
module pwbit_control
  import pwbit_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  stat_t stat,
  output ctrl_t ctrl
);

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    unique case (state)
      ST_HUNT: begin
        if (stat.fallEdge) begin
          ctrl.clrCnt  = 1'b1;
          ctrl.clrIdle = 1'b1;
          nextState    = ST_EARLY;
        end else if (stat.atIdle) begin
          ctrl.setIdle = 1'b1;
        end
      end
      ST_EARLY: begin
        if (stat.fallEdge) begin
          // edge before the sample point: malformed, restart here
          ctrl.clrCnt   = 1'b1;
          ctrl.raiseErr = 1'b1;
        end else if (stat.atSample) begin
          ctrl.takeSample = 1'b1;
          nextState       = ST_LATE;
        end else if (stat.atIdle) begin
          ctrl.setIdle = 1'b1;
          nextState    = ST_HUNT;
        end
      end
      ST_LATE: begin
        if (stat.fallEdge) begin
          ctrl.clrCnt = 1'b1;
          nextState   = ST_EARLY;
        end else if (stat.atRelease && stat.lineLow) begin
          ctrl.raiseErr = 1'b1;
          nextState     = ST_HUNT;
        end else if (stat.atIdle) begin
          ctrl.setIdle = 1'b1;
          nextState    = ST_HUNT;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

endmodule

// File: rtl/pwbit_decoder.sv
module pwbit_decoder
  import pwbit_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int CELL_TICKS   = (CLK_HZ / 1000) * 25 / 4,
  parameter int SAMPLE_TICKS = (CLK_HZ / 10000) * 19,
  parameter int GUARD_TICKS  = CLK_HZ / 2000,
  parameter int IDLE_TICKS   = CELL_TICKS * 3 / 2,
  parameter int FILTER_LEN   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic bitValid,
  output logic bitValue,
  output logic timingErr,
  output logic idle
);

  localparam int RELEASE_TICKS = CELL_TICKS - GUARD_TICKS;

  ctrl_t ctrl;
  stat_t stat;

  pwbit_datapath #(
    .SYNC_STAGES  (2),
    .FILTER_LEN   (FILTER_LEN),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .RELEASE_TICKS(RELEASE_TICKS),
    .IDLE_TICKS   (IDLE_TICKS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .ctrl     (ctrl),
    .stat     (stat),
    .bitValid (bitValid),
    .bitValue (bitValue),
    .timingErr(timingErr),
    .idle     (idle)
  );

  pwbit_control u_control (
    .clk (clk),
    .rstN(rstN),
    .stat(stat),
    .ctrl(ctrl)
  );

endmodule

// File: rtl/pwbit_checker.sv
module pwbit_checker #(
  parameter int SAMPLE_TICKS = 95000
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic timingErr,
  input logic idle
);

  localparam int GW = $clog2(SAMPLE_TICKS + 2);

  logic [GW-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                              gapCnt <= '0;
    else if (bitValid)                      gapCnt <= GW'(1);
    else if (gapCnt != GW'(SAMPLE_TICKS + 1)) gapCnt <= gapCnt + 1'b1;
  end

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R4
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (gapCnt >= GW'(SAMPLE_TICKS)));

  // R9
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (!idle && !timingErr));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> !timingErr);

  // R8
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idle) |-> !bitValid && !timingErr);

endmodule

bind pwbit_decoder pwbit_checker #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_pwbit_checker (
  .clk      (clk),
  .rstN     (rstN),
  .bitValid (bitValid),
  .timingErr(timingErr),
  .idle     (idle)
);

// File: tb/test_pwbit_decoder.sv
module test_pwbit_decoder;

  localparam int CELL   = 250;
  localparam int SAMPLE = 76;
  localparam int GUARD  = 20;
  localparam int IDLET  = 375;
  localparam int FILT   = 3;
  localparam int NVEC   = 8;

  // {lowLen, cellLen, glitchAt (0 = none), expBit, expErr, requirement}
  localparam int VEC [NVEC][6] = '{
    '{18,  250, 0,   0, 0, 2},
    '{220, 250, 0,   1, 0, 3},
    '{18,  250, 0,   0, 0, 2},
    '{225, 250, 0,   1, 0, 6},
    '{220, 250, 100, 1, 0, 5},
    '{240, 250, 0,   1, 1, 6},
    '{18,  250, 0,   0, 0, 6},
    '{20,  250, 10,  0, 0, 5}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b1;
  logic bitValid, bitValue, timingErr, idle;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int fallCyc = 0;
  int nValid = 0;
  int nErr = 0;
  int lastDelay = 0;
  int refDelay = -1;
  logic lastBit = 1'b0;

  always #10 clk = ~clk;

  pwbit_decoder #(
    .CELL_TICKS  (CELL),
    .SAMPLE_TICKS(SAMPLE),
    .GUARD_TICKS (GUARD),
    .IDLE_TICKS  (IDLET),
    .FILTER_LEN  (FILT)
  ) i_pwbit_decoder (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .bitValid (bitValid),
    .bitValue (bitValue),
    .timingErr(timingErr),
    .idle     (idle)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN && bitValid) begin
      nValid    <= nValid + 1;
      lastBit   <= bitValue;
      lastDelay <= cyc - fallCyc;
    end
    if (rstN && timingErr) nErr <= nErr + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCell(input int lowLen, input int cellLen, input int glitchAt);
    for (int i = 0; i < cellLen; i++) begin
      @(negedge clk);
      if (i == 0) fallCyc = cyc;
      if (glitchAt != 0 && i == glitchAt) lineIn = 1'b1;
      else lineIn = (i < lowLen) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v0, e0;
    repeat (5) @(negedge clk);
    // R1: reset state during reset
    check(bitValid == 1'b0 && timingErr == 1'b0 && idle == 1'b1, "R1 in reset",
          {bitValid, timingErr, idle}, 3'b001);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(bitValid == 1'b0 && timingErr == 1'b0 && idle == 1'b1, "R1 after reset",
          {bitValid, timingErr, idle}, 3'b001);

    // Table walk: R2, R3, R4, R5, R6
    for (int k = 0; k < NVEC; k++) begin
      v0 = nValid;
      e0 = nErr;
      runCell(VEC[k][0], VEC[k][1], VEC[k][2]);
      check(nValid - v0 == 1, $sformatf("R%0d vec%0d valid count", VEC[k][5], k), nValid - v0, 1);
      check(lastBit == VEC[k][3][0], $sformatf("R%0d vec%0d bit", VEC[k][5], k), lastBit, VEC[k][3]);
      check(nErr - e0 == VEC[k][4], $sformatf("R%0d vec%0d err count", VEC[k][5], k), nErr - e0, VEC[k][4]);
      check(idle == 1'b0, $sformatf("R8 vec%0d idle low during stream", k), idle, 0);
      if (refDelay < 0) begin
        refDelay = lastDelay;
        // R4: delay within the allowed latency window
        check(lastDelay >= SAMPLE && lastDelay <= SAMPLE + FILT + 6, "R4 sample delay range",
              lastDelay, SAMPLE);
      end else begin
        check(lastDelay == refDelay, $sformatf("R4 vec%0d constant delay", k), lastDelay, refDelay);
      end
    end

    // R7: second falling edge before the sample point
    v0 = nValid;
    e0 = nErr;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      lineIn = (i < 10) ? 1'b0 : 1'b1;
    end
    runCell(220, 250, 0);
    check(nErr - e0 == 1, "R7 early edge error", nErr - e0, 1);
    check(nValid - v0 == 1, "R7 one bit from restarted cell", nValid - v0, 1);
    check(lastBit == 1'b1, "R7 restarted cell bit", lastBit, 1);
    check(lastDelay == refDelay, "R7 delay from second edge", lastDelay, refDelay);

    // R8: quiet line raises idle
    v0 = nValid;
    repeat (IDLET + 50) @(negedge clk);
    check(idle == 1'b1, "R8 idle after quiet gap", idle, 1);
    check(nValid == v0, "R8 no bit while quiet", nValid - v0, 0);

    // R5: short low blip on an idle line is ignored
    v0 = nValid;
    e0 = nErr;
    @(negedge clk); lineIn = 1'b0;
    @(negedge clk); lineIn = 1'b0;
    @(negedge clk); lineIn = 1'b1;
    repeat (300) @(negedge clk);
    check(nValid == v0 && nErr == e0, "R5 blip starts no cell", nValid - v0, 0);
    check(idle == 1'b1, "R5 blip leaves idle set", idle, 1);

    // R8: next edge clears idle and decodes normally (R2)
    v0 = nValid;
    runCell(18, 250, 0);
    check(idle == 1'b0, "R8 edge clears idle", idle, 0);
    check(nValid - v0 == 1 && lastBit == 1'b0, "R2 bit after idle", lastBit, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule